// File: doc/BRIEF.md
# Page Pointer List Walker

This block turns one transfer description into the ordered run of (address, length) pieces that a DMA engine moves. The description has a byte count, two 64-bit pointers and a small page-size selector. The first pointer may land anywhere inside a page, so the first piece is cut off where that page ends. If what is left fits into one more page, the second pointer is the address of that page. If more is left, the second pointer is the address of a table of 64-bit page addresses. The walker reads that table one word at a time over a simple request/response port. When a table page is full, its last word points to the next table page.

A walk starts with a one-cycle `start` while the block is idle. Pieces come out as single-cycle `seg_valid` strobes. The walk ends with a one-cycle `done`, and `done_err` marks a walk that hit a bad pointer. Pieces already sent before the error stay valid. No piece follows the error.

Top module: `pgw_walker`

## Requirements
- R1: The page size is 2^(12 + `page_sel`). Every piece after the first starts on a page boundary, and every piece has a length between 1 and the page size.
- R2: The first piece starts at `first_ptr`. Its length is the smaller of `xfer_len` and (page size minus the offset of `first_ptr` within its page).
- R3: A zero `first_ptr` ends the walk with `done` and `done_err` = 1, and no piece is sent.
- R4: If bytes remain after the first piece and `second_ptr` is zero, the walk ends with `done_err` = 1 after the first piece.
- R5: If the bytes left after the first piece are no more than one page, one piece of exactly that length is sent at `second_ptr`. A `second_ptr` that is not page-aligned ends the walk in error instead.
- R6: If more than one page is left, `second_ptr` is the base of a table. Entry k is read at base + 8k. A read is a one-cycle `rd_req_valid`, only one read is in flight at a time, and the matching `rd_rsp_valid` carries the 64-bit entry. Each entry gives a piece of min(bytes left, page size).
- R7: A table entry that is zero or not page-aligned ends the walk with `done_err` = 1. Pieces sent before it stand, and no piece follows it.
- R8: With E = page size / 8 entries per table page, the entry at index E-1 is a link to the next table page when more than one page is still left. The link is checked for zero and alignment, and reading resumes at index 0 of the page it names. When no more than one page is left at index E-1, that entry is an ordinary data entry.
- R9: `done` is a one-cycle pulse. On success it comes in the same cycle as the last piece. A zero `xfer_len` with a nonzero `first_ptr` gives `done` with no piece and no error.
- R10: `busy` is high from the cycle after an accepted `start` until `done`. A `start` while `busy` is high is ignored.
- R11: After reset, `busy`, `seg_valid`, `rd_req_valid` and `done` are low.
- R12: No table entry beyond those the transfer needs is read. The number of reads equals the number of pieces taken from tables plus the number of links followed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| xfer_len | input | 32 | Total byte count |
| first_ptr | input | 64 | First pointer, any byte offset |
| second_ptr | input | 64 | Direct page address or table base |
| page_sel | input | 4 | Page size selector, page = 2^(12+page_sel) |
| busy | output | 1 | Walk in progress |
| seg_valid | output | 1 | Piece strobe |
| seg_addr | output | 64 | Piece address |
| seg_len | output | 32 | Piece length in bytes |
| rd_req_valid | output | 1 | Table word read request |
| rd_req_addr | output | 64 | Table word address |
| rd_rsp_valid | input | 1 | Read response strobe |
| rd_rsp_data | input | 64 | Table word |
| done | output | 1 | End-of-walk pulse |
| done_err | output | 1 | Walk ended on a bad pointer |

## Verification
Two things can happen in the same cycle: the last piece goes out while `done` ends the walk, and the index reaches the last table slot, where the choice between link and data depends on the bytes left. The bench drives walks where exactly one page is left at the last slot, and walks where more is left. It also injects bad words at the last slot and in the middle of a table. For each walk it compares the pieces, the read count, the error flag, and whether `done` shared its cycle with the final piece, against a model computed from the requirements.

// File: rtl/pgw_pkg.sv
// Shared types for the page pointer list walker.
package pgw_pkg;
    typedef enum logic [2:0] {
        W_IDLE,
        W_FIRST,
        W_SECOND,
        W_REQ,
        W_WAIT
    } walk_state_e;
endpackage

// File: rtl/pgw_geom.sv
// Page geometry: derives page size, offset mask and last table index
// from the page selector. Assumes LEN_W+1 exceeds the largest page bit count.
module pgw_geom #(
    parameter int ADDR_W    = 64,
    parameter int LEN_W     = 32,
    parameter int SEL_W     = 4,
    parameter int BASE_BITS = 12,
    parameter int IDX_W     = 24
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [LEN_W:0]    page_size,
    output logic [ADDR_W-1:0] page_mask,
    output logic [IDX_W-1:0]  last_idx
);
    localparam int MAX_BITS = BASE_BITS + (1 << SEL_W) - 1;
    localparam int PB_W     = $clog2(MAX_BITS + 1) + 1;

    logic [PB_W-1:0] pg_bits;
    logic [LEN_W:0]  entries;

    // Page bit count and size from the selector
    always_comb begin
        pg_bits   = PB_W'(BASE_BITS) + PB_W'(sel);
        page_size = (LEN_W+1)'(1) << pg_bits;
        entries   = page_size >> 3;
        last_idx  = IDX_W'(entries - (LEN_W+1)'(1));
    end

    // One mask bit per address bit below the page size
    generate
        for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
            assign page_mask[b] = (32'(b) < 32'(pg_bits));
        end
    endgenerate
endmodule

// File: rtl/pgw_min.sv
// Unsigned minimum of two equal-width values.
module pgw_min #(
    parameter int W = 33
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    // Pick the smaller operand
    always_comb y = (a < b) ? a : b;
endmodule

// File: rtl/pgw_ptr_chk.sv
// Pointer sanity test: flags a zero pointer and a pointer with offset bits set.
module pgw_ptr_chk #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] mask,
    output logic              is_zero,
    output logic              misaligned
);
    // Zero and alignment flags
    always_comb begin
        is_zero    = (ptr == '0);
        misaligned = ((ptr & mask) != '0);
    end
endmodule

// File: rtl/pgw_walker.sv
// Page pointer list walker: emits (address, length) pieces for one transfer,
// reading table words one at a time. Assumes one response per request and
// that the responder never answers without a request outstanding.
module pgw_walker #(
    parameter int ADDR_W    = 64,
    parameter int LEN_W     = 32,
    parameter int SEL_W     = 4,
    parameter int BASE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic [ADDR_W-1:0] first_ptr,
    input  logic [ADDR_W-1:0] second_ptr,
    input  logic [SEL_W-1:0]  page_sel,
    output logic              busy,
    output logic              seg_valid,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    output logic              rd_req_valid,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [ADDR_W-1:0] rd_rsp_data,
    output logic              done,
    output logic              done_err
);
    import pgw_pkg::*;

    localparam int MAX_BITS = BASE_BITS + (1 << SEL_W) - 1;
    localparam int IDX_W    = MAX_BITS - 3;

    walk_state_e       st;
    logic [LEN_W-1:0]  rem_q;
    logic [ADDR_W-1:0] pa_q, pb_q, base_q;
    logic [SEL_W-1:0]  sel_q;
    logic [IDX_W-1:0]  idx_q;
    logic              seg_valid_q, done_q, err_q;
    logic [ADDR_W-1:0] seg_addr_q;
    logic [LEN_W-1:0]  seg_len_q;

    logic [LEN_W:0]    pg_size;
    logic [ADDR_W-1:0] pg_mask;
    logic [IDX_W-1:0]  last_idx;
    logic [LEN_W:0]    room, first_len, list_len;
    logic              rem_gt_page;
    logic              pb_zero, pb_mis, rsp_zero, rsp_mis;

    pgw_geom #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEL_W(SEL_W),
        .BASE_BITS(BASE_BITS), .IDX_W(IDX_W)
    ) geom_i (
        .sel(sel_q), .page_size(pg_size), .page_mask(pg_mask), .last_idx(last_idx)
    );

    // Bytes up to the end of the first pointer's page
    always_comb room = pg_size - (LEN_W+1)'(pa_q & pg_mask);

    pgw_min #(.W(LEN_W+1)) first_min_i (
        .a({1'b0, rem_q}), .b(room), .y(first_len)
    );

    pgw_min #(.W(LEN_W+1)) list_min_i (
        .a({1'b0, rem_q}), .b(pg_size), .y(list_len)
    );

    pgw_ptr_chk #(.ADDR_W(ADDR_W)) pb_chk_i (
        .ptr(pb_q), .mask(pg_mask), .is_zero(pb_zero), .misaligned(pb_mis)
    );

    pgw_ptr_chk #(.ADDR_W(ADDR_W)) rsp_chk_i (
        .ptr(rd_rsp_data), .mask(pg_mask), .is_zero(rsp_zero), .misaligned(rsp_mis)
    );

    // More than one page still to cover
    always_comb rem_gt_page = ({1'b0, rem_q} > pg_size);

    // Walk sequencing, piece generation and end reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= W_IDLE;
            rem_q       <= '0;
            pa_q        <= '0;
            pb_q        <= '0;
            base_q      <= '0;
            sel_q       <= '0;
            idx_q       <= '0;
            seg_valid_q <= 1'b0;
            seg_addr_q  <= '0;
            seg_len_q   <= '0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            seg_valid_q <= 1'b0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            unique case (st)
                W_IDLE: begin
                    if (start) begin
                        rem_q <= xfer_len;
                        pa_q  <= first_ptr;
                        pb_q  <= second_ptr;
                        sel_q <= page_sel;
                        st    <= W_FIRST;
                    end
                end
                W_FIRST: begin
                    if (pa_q == '0) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                        st     <= W_IDLE;
                    end else if (rem_q == '0) begin
                        done_q <= 1'b1;
                        st     <= W_IDLE;
                    end else begin
                        seg_valid_q <= 1'b1;
                        seg_addr_q  <= pa_q;
                        seg_len_q   <= first_len[LEN_W-1:0];
                        rem_q       <= rem_q - first_len[LEN_W-1:0];
                        if ({1'b0, rem_q} == first_len) begin
                            done_q <= 1'b1;
                            st     <= W_IDLE;
                        end else begin
                            st <= W_SECOND;
                        end
                    end
                end
                W_SECOND: begin
                    if (pb_zero || (!rem_gt_page && pb_mis)) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                        st     <= W_IDLE;
                    end else if (!rem_gt_page) begin
                        seg_valid_q <= 1'b1;
                        seg_addr_q  <= pb_q;
                        seg_len_q   <= rem_q;
                        rem_q       <= '0;
                        done_q      <= 1'b1;
                        st          <= W_IDLE;
                    end else begin
                        base_q <= pb_q;
                        idx_q  <= '0;
                        st     <= W_REQ;
                    end
                end
                W_REQ: begin
                    st <= W_WAIT;
                end
                W_WAIT: begin
                    if (rd_rsp_valid) begin
                        if (rsp_zero || rsp_mis) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                            st     <= W_IDLE;
                        end else if (idx_q == last_idx && rem_gt_page) begin
                            base_q <= rd_rsp_data;
                            idx_q  <= '0;
                            st     <= W_REQ;
                        end else begin
                            seg_valid_q <= 1'b1;
                            seg_addr_q  <= rd_rsp_data;
                            seg_len_q   <= list_len[LEN_W-1:0];
                            rem_q       <= rem_q - list_len[LEN_W-1:0];
                            idx_q       <= idx_q + 1'b1;
                            if ({1'b0, rem_q} == list_len) begin
                                done_q <= 1'b1;
                                st     <= W_IDLE;
                            end else begin
                                st <= W_REQ;
                            end
                        end
                    end
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    // Output wiring from state and registered results
    always_comb begin
        busy         = (st != W_IDLE);
        seg_valid    = seg_valid_q;
        seg_addr     = seg_addr_q;
        seg_len      = seg_len_q;
        done         = done_q;
        done_err     = err_q;
        rd_req_valid = (st == W_REQ);
        rd_req_addr  = base_q + (ADDR_W'(idx_q) << 3);
    end
endmodule

// File: rtl/pgw_walker_chk.sv
// Protocol checker for the walker; bound to every instance of the top.
module pgw_walker_chk #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              seg_valid,
    input logic [ADDR_W-1:0] seg_addr,
    input logic [LEN_W-1:0]  seg_len,
    input logic              rd_req_valid,
    input logic              done,
    input logic              done_err,
    input logic [LEN_W:0]    page_size,
    input logic [ADDR_W-1:0] page_mask
);
    logic seen_seg;

    // Tracks whether the current walk has already sent its first piece
    always_ff @(posedge clk) begin
        if (!rst_n)                seen_seg <= 1'b0;
        else if (start && !busy)   seen_seg <= 1'b0;
        else if (seg_valid)        seen_seg <= 1'b1;
    end

    assert_seg_len_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_len != '0) && ({1'b0, seg_len} <= page_size));

    assert_later_seg_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && seen_seg) |-> ((seg_addr & page_mask) == '0));

    assert_err_no_seg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err) |-> !seg_valid);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |=> !rd_req_valid);

    assert_req_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> busy);

    assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

bind pgw_walker pgw_walker_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .seg_valid(seg_valid), .seg_addr(seg_addr), .seg_len(seg_len),
    .rd_req_valid(rd_req_valid), .done(done), .done_err(done_err),
    .page_size(pg_size), .page_mask(pg_mask)
);

// File: tb/pgw_walker_tb_top.sv
// Bench: directed corners plus seeded random walks, checked against a model.
module pgw_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] xfer_len = '0;
    logic [63:0] first_ptr = '0, second_ptr = '0;
    logic [3:0]  page_sel = '0;
    logic        busy, seg_valid, rd_req_valid, done, done_err;
    logic [63:0] seg_addr, rd_req_addr;
    logic [31:0] seg_len;
    logic        rd_rsp_valid = 1'b0;
    logic [63:0] rd_rsp_data = '0;

    int tests = 0, fails = 0;

    logic [63:0] bad_addr = '1, bad_val = '0;
    logic [63:0] exp_addr [0:2047];
    logic [31:0] exp_len  [0:2047];
    int exp_n, exp_reads;
    bit exp_err;
    logic [63:0] got_addr [0:2047];
    logic [31:0] got_len  [0:2047];
    int got_n = 0, got_reads = 0;
    bit done_seen = 0, done_err_seen = 0, done_with_seg = 0;

    always #5 clk = ~clk;

    pgw_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
        .first_ptr(first_ptr), .second_ptr(second_ptr), .page_sel(page_sel),
        .busy(busy), .seg_valid(seg_valid), .seg_addr(seg_addr), .seg_len(seg_len),
        .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .done(done), .done_err(done_err)
    );

    function automatic logic [63:0] mem_word(input logic [63:0] a);
        if (a == bad_addr) return bad_val;
        return ((a >> 3) + 64'd1) << 20;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [63:0] a, input longint unsigned l);
        if (exp_n < 2048) begin
            exp_addr[exp_n] = a;
            exp_len[exp_n]  = 32'(l);
        end
        exp_n++;
    endtask

    // Expected pieces, error and read count from the requirements
    task automatic model(input logic [31:0] len, input logic [63:0] pa,
                         input logic [63:0] pb, input logic [3:0] sel);
        longint unsigned psz, rem, f, base, e, l;
        int idx, epp;
        exp_n = 0; exp_err = 0; exp_reads = 0;
        psz = 64'd1 << (12 + sel);
        if (pa == 0) begin exp_err = 1; return; end
        if (len == 0) return;
        f = psz - (pa % psz);
        if (len < f) f = len;
        push(pa, f);
        rem = len - f;
        if (rem == 0) return;
        if (pb == 0) begin exp_err = 1; return; end
        if (rem <= psz) begin
            if (pb % psz != 0) exp_err = 1;
            else push(pb, rem);
            return;
        end
        base = pb; idx = 0; epp = int'(psz / 8);
        while (rem > 0) begin
            e = mem_word(base + 64'(idx) * 8);
            exp_reads++;
            if (e == 0 || e % psz != 0) begin exp_err = 1; return; end
            if (idx == epp - 1 && rem > psz) begin
                base = e; idx = 0;
            end else begin
                l = (rem < psz) ? rem : psz;
                push(e, l);
                rem -= l;
                idx++;
            end
        end
    endtask

    // Table memory responder with 1..3 cycle latency
    initial begin
        forever begin
            @(negedge clk);
            rd_rsp_valid = 1'b0;
            if (rst_n && rd_req_valid) begin
                logic [63:0] a;
                int lat;
                a = rd_req_addr;
                lat = $urandom_range(1, 3);
                repeat (lat) @(negedge clk);
                rd_rsp_data  = mem_word(a);
                rd_rsp_valid = 1'b1;
            end
        end
    end

    // Output monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (seg_valid) begin
                    if (got_n < 2048) begin
                        got_addr[got_n] = seg_addr;
                        got_len[got_n]  = seg_len;
                    end
                    got_n++;
                end
                if (rd_req_valid) got_reads++;
                if (done) begin
                    done_seen     = 1;
                    done_err_seen = done_err;
                    done_with_seg = seg_valid;
                end
            end
        end
    end

    task automatic run_walk(input logic [31:0] len, input logic [63:0] pa,
                            input logic [63:0] pb, input logic [3:0] sel,
                            input bit poke, input string req);
        int t;
        int bad_i;
        model(len, pa, pb, sel);
        @(negedge clk);
        got_n = 0; got_reads = 0; done_seen = 0;
        start = 1'b1; xfer_len = len; first_ptr = pa; second_ptr = pb; page_sel = sel;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            check(busy == 1'b1, "R10", "busy mid-walk", 64'(busy), 64'd1);
            start = 1'b1; xfer_len = 32'd1; first_ptr = '0; page_sel = 4'd3;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done_seen && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        check(done_seen, req, "done seen", 64'(done_seen), 64'd1);
        check(done_err_seen == exp_err, req, "error flag", 64'(done_err_seen), 64'(exp_err));
        check(got_n == exp_n, req, "piece count", 64'(got_n), 64'(exp_n));
        bad_i = -1;
        for (int i = 0; i < exp_n && i < got_n && i < 2048; i++)
            if (bad_i < 0 && (got_addr[i] != exp_addr[i] || got_len[i] != exp_len[i])) bad_i = i;
        if (bad_i >= 0)
            check(0, req, "piece addr/len", {got_addr[bad_i][31:0], got_len[bad_i]},
                  {exp_addr[bad_i][31:0], exp_len[bad_i]});
        else
            check(1, req, "pieces", 0, 0);
        check(got_reads == exp_reads, "R12", "table reads", 64'(got_reads), 64'(exp_reads));
        if (!exp_err && exp_n > 0)
            check(done_with_seg, "R9", "done with last piece", 64'(done_with_seg), 64'd1);
        bad_addr = '1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(!busy && !seg_valid && !rd_req_valid && !done, "R11", "reset outputs",
              {busy, seg_valid, rd_req_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R11", "idle after reset", {busy, done}, 0);

        run_walk(32'd512, 64'h0004_0100, 64'h0, 4'd0, 0, "R2");
        run_walk(32'h400, 64'h1000_0F00, 64'h2000_0000, 4'd0, 0, "R5");
        run_walk(32'h400, 64'h1000_0F00, 64'h2000_0040, 4'd0, 0, "R5");
        run_walk(32'h400, 64'h0, 64'h2000_0000, 4'd0, 0, "R3");
        run_walk(32'h400, 64'h1000_0F00, 64'h0, 4'd0, 0, "R4");
        run_walk(32'd0, 64'h0003_0000, 64'h0, 4'd0, 0, "R9");
        run_walk(32'h5300, 64'h0005_0800, 64'h0900_0000, 4'd0, 0, "R6");
        run_walk(32'h5300, 64'h0005_0800, 64'h0900_0000, 4'd0, 1, "R10");
        bad_addr = 64'h0900_0010; bad_val = 64'h0;
        run_walk(32'h5300, 64'h0005_0800, 64'h0900_0000, 4'd0, 0, "R7");
        bad_addr = 64'h0900_0008; bad_val = 64'h0123_4800;
        run_walk(32'h5300, 64'h0005_0800, 64'h0900_0000, 4'd0, 0, "R7");
        run_walk(32'd4096 * 516, 64'h0004_0000, 64'h0A00_0000, 4'd0, 0, "R8");
        run_walk(32'd4096 * 513, 64'h0004_0000, 64'h0A00_0000, 4'd0, 0, "R8");
        bad_addr = 64'h0A00_0000 + 64'd8 * 511; bad_val = 64'h0123_4800;
        run_walk(32'd4096 * 516, 64'h0004_0000, 64'h0A00_0000, 4'd0, 0, "R8");
        run_walk(32'h9000, 64'h0010_3000, 64'h0B00_0000, 4'd2, 0, "R1");
        run_walk(32'h2800, 64'h0010_3000, 64'h0C00_4000, 4'd2, 0, "R1");

        for (int n = 0; n < 40; n++) begin
            logic [3:0] sel;
            longint unsigned psz;
            logic [63:0] pa, pb;
            logic [31:0] len;
            int pages;
            sel = 4'($urandom_range(0, 2));
            psz = 64'd1 << (12 + sel);
            pa  = (64'($urandom_range(1, 4095)) << 16) + 64'($urandom_range(0, int'(psz) - 1));
            if ($urandom_range(0, 3) == 0) pa = pa & ~(psz - 1);
            len = 32'($urandom_range(0, int'(psz) * 12));
            pb  = 64'($urandom_range(1, 4095)) << 24;
            case ($urandom_range(0, 15))
                0: pb = '0;
                1: pb = pb + 64'd8;
                default: ;
            endcase
            pages = int'(64'(len) / psz) + 1;
            if ($urandom_range(0, 5) == 0) begin
                bad_addr = pb + 64'($urandom_range(0, pages)) * 8;
                bad_val  = ($urandom_range(0, 1) == 0) ? 64'h0 : 64'h0040_0008;
            end
            run_walk(len, pa, pb, sel, 0, "R6");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule